// File: doc/BRIEF.md
# Chained Scatter-Gather DMA Sequencer

This block sequences one DMA channel. Software programs a mode word, a transfer's PCI address, local address and byte count, and a pointer to a descriptor. It then sets the start bit in a byte-wide command/status register. In chaining mode the sequencer reads 16-byte descriptors from memory through a simple 32-bit request/acknowledge port. It hands each descriptor to an external data mover and follows the next-descriptor links until it reaches a descriptor marked as the last one. With chaining off, it runs a single transfer built from the directly written registers and makes no memory access.

The low nibble of each next-descriptor word carries four flags. They give the address space of the next descriptor, mark the end of the chain, ask for an interrupt when this descriptor's count is used up, and set the transfer direction. When the clear-count mode is on, a zero is written back over the count of each finished descriptor. A sticky interrupt line, an abort path and a done flag complete the control handshake with software.

Top module: `sgdma_seq`

## Requirements
- R1: After reset the status byte reads 0x10 (done set, enable clear), the interrupt is low, and neither memory nor mover requests are raised.
- R2: Register select 0 is the command/status byte. On write, bit 0 sets or clears enable, and bits 1 (start), 2 (abort) and 3 (interrupt clear) are actions. On read, bit 0 is enable and bit 4 is done; all other bits read 0. Start is honoured only when it is written with bit 0 set while done is high, and it clears done; otherwise it is ignored.
- R3: In chaining mode (mode bit 9) the descriptor at the pointer's bits 31:4 is read as four words at offsets 0, 4, 8 and 12: PCI address, local address, byte count, next word. memPciSpace shows bit 0 of the word that pointed to that descriptor. A memory request holds its address until it is acknowledged.
- R4: A mover request holds PCI address, local address and count stable until mvAck. The count is the low 23 bits of the count word. mvLocToPci is bit 3 of the next word (1 means local to PCI). mvLocConst follows mode bit 11.
- R5: After each transfer the chain continues at next[31:4] in the space given by next bit 0. The chain stops after the transfer of a descriptor whose next bit 1 is set, and done is then raised.
- R6: With mode bit 9 clear, one transfer runs from registers 2 (PCI address), 3 (local address) and 4 (count). Direction and the terminal-count flag are taken from bits 3 and 2 of register 5, and no memory access is made. Register 1 is the mode word.
- R7: In chaining mode with mode bit 16 set, a zero is written to offset 8 of each descriptor after its transfer, before the next fetch or before done.
- R8: The interrupt is sticky. It is set on normal completion when mode bit 10 is set, and after the transfer of any descriptor with next bit 2 set. A command write with bit 3 set clears it.
- R9: Abort is honoured only while enable is set and done is low. It takes effect at the next mover or memory acknowledge. After that no descriptor is fetched and done rises. An abort while done is high changes nothing but the enable bit it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select (0 cmd/status, 1 mode, 2 PCI addr, 3 local addr, 4 count, 5 pointer) |
| cfgWdata | input | 32 | Register write data |
| statusByte | output | 8 | Command/status read value |
| irq | output | 1 | Sticky channel interrupt |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memPciSpace | output | 1 | Descriptor lives in PCI space |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access done |
| mvReq | output | 1 | Transfer request to the data mover |
| mvPciAddr | output | 32 | Transfer PCI start address |
| mvLocAddr | output | 32 | Transfer local start address |
| mvCount | output | 23 | Transfer byte count |
| mvLocToPci | output | 1 | Direction, 1 = local to PCI |
| mvLocConst | output | 1 | Hold the local address constant |
| mvAck | input | 1 | Mover finished the transfer |

## Verification
The bench drives count words with bits set above bit 22. A design that kept too many count bits would hand the mover a huge count. Chains of one to four descriptors with alternating space and direction flags test that links and flags come from the right word; a sequencer that read the flags of the next descriptor instead would show the wrong direction or space. Clear-count runs check memory afterwards, where a write-back aimed at the wrong offset or skipped in the last descriptor shows up as a surviving count. An abort raised while the mover stalls must keep done low until the acknowledge and must not fetch again. A start written with enable clear must leave the channel idle.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  // register select codes
  localparam logic [2:0] SEL_CSR  = 3'd0;
  localparam logic [2:0] SEL_MODE = 3'd1;
  localparam logic [2:0] SEL_PCI  = 3'd2;
  localparam logic [2:0] SEL_LOC  = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;
  localparam logic [2:0] SEL_PTR  = 3'd5;

  // command/status bit positions
  localparam int CSR_EN   = 0;
  localparam int CSR_GO   = 1;
  localparam int CSR_ABT  = 2;
  localparam int CSR_ICLR = 3;
  localparam int CSR_DONE = 4;

  // mode word bit positions
  localparam int MODE_CHAIN  = 9;
  localparam int MODE_DIEN   = 10;
  localparam int MODE_LCONST = 11;
  localparam int MODE_CLR    = 16;

  // next-word flag positions
  localparam int NX_PCI = 0;
  localparam int NX_END = 1;
  localparam int NX_TC  = 2;
  localparam int NX_DIR = 3;

  localparam int DESC_WORDS = 4;
  localparam int CNT_SLOT   = 2;
  localparam int NEXT_SLOT  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE, ST_WBACK} seqState_t;

  typedef struct packed {
    logic       loadSingle;
    logic       loadChain;
    logic       capWord;
    logic [1:0] wordIdx;
    logic       followNext;
  } dpStrobe_t;
endpackage

// File: rtl/sgdma_dpath.sv
module sgdma_dpath
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memPciSpace,
  output logic [ADDR_W-1:0] mvPciAddr,
  output logic [ADDR_W-1:0] mvLocAddr,
  output logic [CNT_W-1:0]  mvCount,
  output logic              mvLocToPci,
  output logic              modeChain,
  output logic              modeDoneIen,
  output logic              modeClr,
  output logic              modeLConst,
  output logic              curEnd,
  output logic              curTc
);
  localparam int BASE_LSB = 4;

  logic [31:0]       modeReg;
  logic [ADDR_W-1:0] pciReg, locReg, ptrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [31:0]       descWord   [DESC_WORDS];
  logic [31:0]       singleWord [DESC_WORDS];
  logic [ADDR_W-1:BASE_LSB] curBase;
  logic              curSpace;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      pciReg  <= '0;
      locReg  <= '0;
      cntReg  <= '0;
      ptrReg  <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_MODE: modeReg <= cfgWdata;
        SEL_PCI:  pciReg  <= cfgWdata[ADDR_W-1:0];
        SEL_LOC:  locReg  <= cfgWdata[ADDR_W-1:0];
        SEL_CNT:  cntReg  <= cfgWdata[CNT_W-1:0];
        SEL_PTR:  ptrReg  <= cfgWdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    singleWord[0] = 32'(pciReg);
    singleWord[1] = 32'(locReg);
    singleWord[CNT_SLOT]  = 32'(cntReg);
    singleWord[NEXT_SLOT] = 32'(ptrReg);
  end

  for (genvar k = 0; k < DESC_WORDS; k++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        descWord[k] <= '0;
      else if (strobe.loadSingle)
        descWord[k] <= singleWord[k];
      else if (strobe.capWord && strobe.wordIdx == 2'(k))
        descWord[k] <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBase  <= '0;
      curSpace <= 1'b0;
    end else if (strobe.loadChain) begin
      curBase  <= ptrReg[ADDR_W-1:BASE_LSB];
      curSpace <= ptrReg[NX_PCI];
    end else if (strobe.followNext) begin
      curBase  <= descWord[NEXT_SLOT][ADDR_W-1:BASE_LSB];
      curSpace <= descWord[NEXT_SLOT][NX_PCI];
    end
  end

  assign memAddr     = {curBase, strobe.wordIdx, 2'b00};
  assign memPciSpace = curSpace;
  assign mvPciAddr   = descWord[0][ADDR_W-1:0];
  assign mvLocAddr   = descWord[1][ADDR_W-1:0];
  assign mvCount     = descWord[CNT_SLOT][CNT_W-1:0];
  assign mvLocToPci  = descWord[NEXT_SLOT][NX_DIR];
  assign curEnd      = descWord[NEXT_SLOT][NX_END];
  assign curTc       = descWord[NEXT_SLOT][NX_TC];
  assign modeChain   = modeReg[MODE_CHAIN];
  assign modeDoneIen = modeReg[MODE_DIEN];
  assign modeClr     = modeReg[MODE_CLR];
  assign modeLConst  = modeReg[MODE_LCONST];
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [2:0] cfgSel,
  input  logic [7:0] csrByte,
  input  logic       modeChain,
  input  logic       modeDoneIen,
  input  logic       modeClr,
  input  logic       curEnd,
  input  logic       curTc,
  input  logic       memAck,
  input  logic       mvAck,
  output dpStrobe_t  strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       mvReq,
  output logic       enable,
  output logic       done,
  output logic       irq
);
  seqState_t state, stateNx;
  logic [1:0] idx, idxNx;
  logic abortPend;
  logic csrWr, startOk, abortOk, abortHit;
  logic finish, normalEnd, irqSet, follow;

  always_comb begin
    csrWr    = cfgWe && (cfgSel == SEL_CSR);
    startOk  = csrWr && csrByte[CSR_GO] && csrByte[CSR_EN] && done;
    abortOk  = csrWr && csrByte[CSR_ABT] && enable && !done;
    abortHit = abortPend || abortOk;

    stateNx   = state;
    idxNx     = idx;
    finish    = 1'b0;
    normalEnd = 1'b0;
    irqSet    = 1'b0;
    follow    = 1'b0;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    mvReq     = 1'b0;

    case (state)
      ST_IDLE: begin
        if (startOk) begin
          idxNx = 2'd0;
          if (modeChain) begin
            strobe.loadChain = 1'b1;
            stateNx = ST_FETCH;
          end else begin
            strobe.loadSingle = 1'b1;
            stateNx = ST_MOVE;
          end
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        strobe.wordIdx = idx;
        if (memAck) begin
          strobe.capWord = 1'b1;
          if (abortHit)
            finish = 1'b1;
          else if (idx == 2'd3)
            stateNx = ST_MOVE;
          else
            idxNx = idx + 2'd1;
        end
      end
      ST_MOVE: begin
        mvReq = 1'b1;
        if (mvAck) begin
          irqSet = curTc;
          if (abortHit)
            finish = 1'b1;
          else if (modeChain && modeClr)
            stateNx = ST_WBACK;
          else if (!modeChain || curEnd) begin
            finish = 1'b1;
            normalEnd = 1'b1;
          end else
            follow = 1'b1;
        end
      end
      ST_WBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.wordIdx = 2'(CNT_SLOT);
        if (memAck) begin
          if (abortHit)
            finish = 1'b1;
          else if (curEnd) begin
            finish = 1'b1;
            normalEnd = 1'b1;
          end else
            follow = 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase

    if (follow) begin
      strobe.followNext = 1'b1;
      idxNx = 2'd0;
      stateNx = ST_FETCH;
    end
    if (finish) stateNx = ST_IDLE;
    if (normalEnd && modeDoneIen) irqSet = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= 2'd0;
      enable    <= 1'b0;
      done      <= 1'b1;
      irq       <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      state <= stateNx;
      idx   <= idxNx;
      if (csrWr) enable <= csrByte[CSR_EN];
      if (startOk) done <= 1'b0;
      else if (finish) done <= 1'b1;
      if (startOk || finish) abortPend <= 1'b0;
      else if (abortOk) abortPend <= 1'b1;
      if (irqSet) irq <= 1'b1;
      else if (csrWr && csrByte[CSR_ICLR]) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [7:0]        statusByte,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memPciSpace,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              mvReq,
  output logic [ADDR_W-1:0] mvPciAddr,
  output logic [ADDR_W-1:0] mvLocAddr,
  output logic [CNT_W-1:0]  mvCount,
  output logic              mvLocToPci,
  output logic              mvLocConst,
  input  logic              mvAck
);
  dpStrobe_t strobe;
  logic modeChain, modeDoneIen, modeClr, curEnd, curTc;
  logic enable, done;

  sgdma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .csrByte(cfgWdata[7:0]), .modeChain(modeChain), .modeDoneIen(modeDoneIen),
    .modeClr(modeClr), .curEnd(curEnd), .curTc(curTc), .memAck(memAck),
    .mvAck(mvAck), .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .mvReq(mvReq), .enable(enable), .done(done), .irq(irq)
  );

  sgdma_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .strobe(strobe), .memRdata(memRdata), .memAddr(memAddr),
    .memPciSpace(memPciSpace), .mvPciAddr(mvPciAddr), .mvLocAddr(mvLocAddr),
    .mvCount(mvCount), .mvLocToPci(mvLocToPci), .modeChain(modeChain),
    .modeDoneIen(modeDoneIen), .modeClr(modeClr), .modeLConst(mvLocConst),
    .curEnd(curEnd), .curTc(curTc)
  );

  always_comb begin
    statusByte = '0;
    statusByte[CSR_EN]   = enable;
    statusByte[CSR_DONE] = done;
  end

  assign memWdata = '0;
endmodule

// File: rtl/sgdma_seq_chk.sv
module sgdma_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [2:0]        cfgSel,
  input logic [31:0]       cfgWdata,
  input logic [7:0]        statusByte,
  input logic              irq,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              mvReq,
  input logic [ADDR_W-1:0] mvPciAddr,
  input logic [ADDR_W-1:0] mvLocAddr,
  input logic [CNT_W-1:0]  mvCount,
  input logic              mvAck
);
  logic csrWr;
  assign csrWr = cfgWe && (cfgSel == 3'd0);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[4] |-> (!memReq && !mvReq)) else $error("idle request"); // R1

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && mvReq)) else $error("both requests"); // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))) else $error("mem drop"); // R3

  AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mvReq && !mvAck) |=> (mvReq && $stable(mvPciAddr) && $stable(mvLocAddr)
                          && $stable(mvCount))) else $error("mover drop"); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(csrWr && cfgWdata[3])) |=> irq) else $error("irq lost"); // R8

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[4] && csrWr && cfgWdata[1] && !cfgWdata[0]) |=> statusByte[4])
    else $error("start without enable"); // R2

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[4] && csrWr && cfgWdata[2] && !cfgWdata[1]) |=> statusByte[4])
    else $error("abort when idle"); // R9
endmodule

bind sgdma_seq sgdma_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
  .statusByte(statusByte), .irq(irq), .memReq(memReq), .memAddr(memAddr),
  .memAck(memAck), .mvReq(mvReq), .mvPciAddr(mvPciAddr), .mvLocAddr(mvLocAddr),
  .mvCount(mvCount), .mvAck(mvAck)
);

// File: tb/tb_sgdma_seq.sv
module tb_sgdma_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [7:0] statusByte;
  logic irq, memReq, memWe, memPciSpace, mvReq, mvLocToPci, mvLocConst;
  logic [31:0] memAddr, memWdata, mvPciAddr, mvLocAddr;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;
  logic mvAck = 1'b0;
  logic [22:0] mvCount;

  always #5 clk = ~clk;

  sgdma_seq dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .statusByte(statusByte), .irq(irq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memPciSpace(memPciSpace), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .mvReq(mvReq), .mvPciAddr(mvPciAddr),
    .mvLocAddr(mvLocAddr), .mvCount(mvCount), .mvLocToPci(mvLocToPci),
    .mvLocConst(mvLocConst), .mvAck(mvAck)
  );

  // memory and mover models with logging
  logic [31:0] mem [128];
  logic [31:0] xPci [8];
  logic [31:0] xLoc [8];
  logic [22:0] xCnt [8];
  logic xDir [8];
  logic xLc  [8];
  logic fSpace [8];
  int xCount = 0, fCount = 0, memAccess = 0;
  logic clrLog = 1'b0;
  logic mvHold = 1'b0;

  always @(negedge clk) begin
    if (clrLog) begin
      xCount = 0; fCount = 0; memAccess = 0;
    end
    if (memReq && !memAck) begin
      memAck = 1'b1;
      memAccess = memAccess + 1;
      if (memWe) mem[memAddr[8:2]] = memWdata;
      else begin
        memRdata = mem[memAddr[8:2]];
        if (memAddr[3:2] == 2'd0 && fCount < 8) begin
          fSpace[fCount] = memPciSpace;
          fCount = fCount + 1;
        end
      end
    end else memAck = 1'b0;
    if (mvReq && !mvAck && !mvHold) begin
      mvAck = 1'b1;
      if (xCount < 8) begin
        xPci[xCount] = mvPciAddr; xLoc[xCount] = mvLocAddr; xCnt[xCount] = mvCount;
        xDir[xCount] = mvLocToPci; xLc[xCount] = mvLocConst;
      end
      xCount = xCount + 1;
    end else mvAck = 1'b0;
  end

  int nChk = 0, nFail = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic resetLog();
    @(negedge clk); clrLog = 1'b1;
    @(negedge clk); clrLog = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!statusByte[4] && n < 3000) begin @(negedge clk); n++; end
    chk(statusByte[4], tag, {31'd0, statusByte[4]}, 32'd1);
  endtask

  function automatic logic [31:0] descBase(input int i);
    return 32'h80 + 32'(i) * 32'h10;
  endfunction

  task automatic buildChain(input int n, input int tcIdx, input logic sp0);
    for (int i = 0; i < n; i++) begin
      logic [31:0] nx;
      int w = int'(descBase(i) >> 2);
      nx = descBase(i + 1);
      nx[0] = sp0 ^ logic'((i + 1) % 2);
      nx[1] = (i == n - 1);
      nx[2] = (i == tcIdx);
      nx[3] = logic'(i % 2);
      mem[w]     = 32'h1000_0000 + 32'(i) * 32'h100;
      mem[w + 1] = 32'h2000_0000 + 32'(i) * 32'h40;
      mem[w + 2] = 32'hFF80_0000 | (32'h20 + 32'(i));
      mem[w + 3] = nx;
    end
  endtask

  // vector: chain, doneIen, clrCnt, nDesc[3], tcIdx[3] (7 none), sp0, expIrq, expXfer[3], pad[2]
  localparam int NV = 6;
  localparam logic [15:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b0, 3'd3, 3'd7, 1'b0, 1'b1, 3'd3, 2'b00},
    {1'b1, 1'b0, 1'b1, 3'd2, 3'd7, 1'b1, 1'b0, 3'd2, 2'b00},
    {1'b1, 1'b0, 1'b0, 3'd4, 3'd1, 1'b0, 1'b1, 3'd4, 2'b00},
    {1'b1, 1'b1, 1'b1, 3'd1, 3'd0, 1'b1, 1'b1, 3'd1, 2'b00},
    {1'b0, 1'b1, 1'b1, 3'd1, 3'd7, 1'b0, 1'b1, 3'd1, 2'b00},
    {1'b0, 1'b0, 1'b0, 3'd1, 3'd7, 1'b0, 1'b0, 3'd1, 2'b00}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(statusByte == 8'h10, "R1 status after reset", {24'd0, statusByte}, 32'h10);
    chk(!irq && !memReq && !mvReq, "R1 quiet after reset",
        {29'd0, irq, memReq, mvReq}, 32'd0);

    // R2 start with enable clear is ignored
    buildChain(2, 7, 1'b0);
    cfgWrite(3'd1, 32'h0000_0200);
    cfgWrite(3'd5, 32'h80);
    resetLog();
    cfgWrite(3'd0, 32'h02);
    repeat (6) @(negedge clk);
    chk(statusByte == 8'h10, "R2 start without enable ignored", {24'd0, statusByte}, 32'h10);
    chk(memAccess == 0, "R2 no fetch after ignored start", 32'(memAccess), 32'd0);

    // table-driven runs
    for (int v = 0; v < NV; v++) begin
      logic [15:0] vec;
      logic chain, dien, clr, sp0, expIrq, lc;
      int n, tcIdx, expX;
      vec = VECS[v];
      chain = vec[15]; dien = vec[14]; clr = vec[13];
      n = int'(vec[12:10]); tcIdx = int'(vec[9:7]); sp0 = vec[6];
      expIrq = vec[5]; expX = int'(vec[4:2]);
      lc = logic'(v % 2);
      buildChain(n, tcIdx, sp0);
      cfgWrite(3'd1, {15'd0, clr, 4'd0, lc, dien, chain, 9'd0});
      if (chain) cfgWrite(3'd5, 32'h80 | {31'd0, sp0});
      else begin
        cfgWrite(3'd2, 32'h3000_0000 + 32'(v));
        cfgWrite(3'd3, 32'h4000_0010);
        cfgWrite(3'd4, 32'hFFFF_FFF0);
        cfgWrite(3'd5, (v == 4) ? 32'h0000_1008 : 32'h0000_1000);
      end
      resetLog();
      cfgWrite(3'd0, 32'h03);
      waitDone("R5 run completes");
      chk(xCount == expX, "R5 transfer count", 32'(xCount), 32'(expX));
      if (chain) begin
        for (int i = 0; i < expX; i++) begin
          logic [31:0] w2;
          chk(xPci[i] == 32'h1000_0000 + 32'(i) * 32'h100, "R3 pci address",
              xPci[i], 32'h1000_0000 + 32'(i) * 32'h100);
          chk(xLoc[i] == 32'h2000_0000 + 32'(i) * 32'h40, "R3 local address",
              xLoc[i], 32'h2000_0000 + 32'(i) * 32'h40);
          chk(xCnt[i] == 23'h20 + 23'(i), "R4 count low 23 bits",
              {9'd0, xCnt[i]}, 32'h20 + 32'(i));
          chk(xDir[i] == logic'(i % 2), "R4 direction", {31'd0, xDir[i]}, 32'(i % 2));
          chk(xLc[i] == lc, "R4 local constant", {31'd0, xLc[i]}, {31'd0, lc});
          chk(fSpace[i] == (sp0 ^ logic'(i % 2)), "R3 descriptor space",
              {31'd0, fSpace[i]}, {31'd0, sp0 ^ logic'(i % 2)});
          w2 = mem[int'(descBase(i) >> 2) + 2];
          if (clr) chk(w2 == 32'd0, "R7 count cleared", w2, 32'd0);
          else chk(w2 == (32'hFF80_0000 | (32'h20 + 32'(i))), "R7 count untouched",
                   w2, 32'hFF80_0000 | (32'h20 + 32'(i)));
        end
      end else begin
        chk(xPci[0] == 32'h3000_0000 + 32'(v), "R6 single pci", xPci[0],
            32'h3000_0000 + 32'(v));
        chk(xLoc[0] == 32'h4000_0010, "R6 single local", xLoc[0], 32'h4000_0010);
        chk(xCnt[0] == 23'h7F_FFF0, "R4 single count masked", {9'd0, xCnt[0]}, 32'h7F_FFF0);
        chk(xDir[0] == (v == 4), "R6 single direction", {31'd0, xDir[0]}, 32'(v == 4));
        chk(memAccess == 0, "R6 no memory access", 32'(memAccess), 32'd0);
      end
      chk(irq == expIrq, "R8 interrupt", {31'd0, irq}, {31'd0, expIrq});
      cfgWrite(3'd0, 32'h09);
      @(negedge clk);
      chk(!irq, "R8 interrupt cleared", {31'd0, irq}, 32'd0);
      chk(statusByte == 8'h11, "R2 status enable and done", {24'd0, statusByte}, 32'h11);
    end

    // R9 abort during a stalled transfer
    buildChain(3, 7, 1'b0);
    cfgWrite(3'd1, 32'h0000_0200);
    cfgWrite(3'd5, 32'h80);
    resetLog();
    mvHold = 1'b1;
    cfgWrite(3'd0, 32'h03);
    begin
      int n = 0;
      while (!mvReq && n < 200) begin @(negedge clk); n++; end
    end
    cfgWrite(3'd0, 32'h05);
    repeat (4) @(negedge clk);
    chk(!statusByte[4], "R9 done low until acknowledge", {31'd0, statusByte[4]}, 32'd0);
    mvHold = 1'b0;
    waitDone("R9 done after abort");
    repeat (4) @(negedge clk);
    chk(xCount == 1, "R9 one transfer only", 32'(xCount), 32'd1);
    chk(fCount == 1, "R9 no fetch after abort", 32'(fCount), 32'd1);
    chk(!memReq && !mvReq, "R9 quiet after abort", {30'd0, memReq, mvReq}, 32'd0);

    // R9 abort while idle ignored
    resetLog();
    cfgWrite(3'd0, 32'h05);
    repeat (4) @(negedge clk);
    chk(statusByte == 8'h11, "R9 idle abort ignored", {24'd0, statusByte}, 32'h11);
    chk(memAccess == 0 && xCount == 0, "R9 idle abort no activity",
        32'(memAccess + xCount), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule